// File: doc/BRIEF.md
# First-Available DRAM Command Scheduler

This block sits behind a set of per-bank command queues that are spread over several ranks. Each queue shows the command at its head: an activate, a column read, a column write or a precharge, with a fetch flag and an age stamp taken when the command was enqueued. In every clock cycle the scheduler checks every head against the timing state of its bank, of its rank and of the shared data bus. Only commands that may legally go on the command bus in that cycle are eligible. From those it picks one, using a tiebreak rule chosen at run time. It then reports the winning command, rank and bank in the same cycle, so the owning queue can pop it.

The timing rules are held as countdown counters. Each bank keeps how long it must wait before its next activate, its next column command and its next precharge. Each rank keeps a write-to-read wait and a small set of slots for the rolling four-activate window. A bus tracker keeps when the last data burst ends, and how long the bus must wait when the next burst comes from another rank. All timing values are 8-bit run-time inputs. When no head is legal, nothing is issued and the counters keep counting down.

Top module: `fas_sched`

## Requirements
- R1: After reset every timing counter is clear, so any valid head of any type is legal in the first cycle after reset, whatever the timing inputs hold.
- R2: At most one command issues per cycle. A command issues only if its queue is valid and legal, and one always issues when at least one head is legal. When no head is legal, issue_valid is 0.
- R3: For the same bank, an activate issues at least t_rp cycles after a precharge, and a read or write issues at least t_rcd cycles after an activate. A precharge issues at least t_ras cycles after an activate. "At least t cycles after" means the difference of issue cycles is at least t.
- R4: A read issued in cycle c drives data over cycles [c+t_cas, c+t_cas+t_burst). A write drives data over [c+t_cwd, c+t_cwd+t_burst). A column command is legal only if its burst starts no earlier than the end of the last burst, plus t_rtrs when the last burst came from another rank.
- R5: A read to a rank issues no earlier than w+t_cwd+t_burst+t_wtr, where w is the cycle of the last write to that rank.
- R6: An activate to a rank in cycle c is legal only if fewer than four activates to that rank were issued in cycles c-t_faw+1 to c-1.
- R7: With tie_mode 0, the legal head with the smallest age stamp wins. Equal ages go to the lowest queue index.
- R8: With tie_mode 1 or 3, the legal head with the lowest queue index wins.
- R9: With tie_mode 2, a head with its fetch flag set comes first, then read commands, then all others. Within a class, the lowest queue index wins.
- R10: Type codes are 0 activate, 1 read, 2 write and 3 precharge. Queue q belongs to rank q / BANKS_PER_RANK and bank q % BANKS_PER_RANK. Queue q's type sits at cand_type[2q+1:2q] and its age at cand_age[8q+7:8q]. issue_type, issue_rank and issue_bank report the winner's fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| t_rcd | input | 8 | Activate to column command, cycles |
| t_rp | input | 8 | Precharge to activate, cycles |
| t_ras | input | 8 | Activate to precharge, cycles |
| t_cas | input | 8 | Read command to read data, cycles |
| t_cwd | input | 8 | Write command to write data, cycles |
| t_burst | input | 8 | Data bus cycles per burst |
| t_rtrs | input | 8 | Extra bus gap when the rank changes |
| t_wtr | input | 8 | End of write burst to read, same rank |
| t_faw | input | 8 | Rolling four-activate window per rank |
| tie_mode | input | 2 | Tiebreak: 0 age, 1 or 3 queue index, 2 class |
| cand_valid | input | 8 | Queue head present, one bit per queue |
| cand_type | input | 16 | Head command type, 2 bits per queue |
| cand_fetch | input | 8 | Head belongs to a fetch, one bit per queue |
| cand_age | input | 64 | Head age stamp, 8 bits per queue, smaller is older |
| issue_valid | output | 1 | A command issues this cycle |
| issue_type | output | 2 | Type of the issued command |
| issue_rank | output | 1 | Rank of the issued command |
| issue_bank | output | 2 | Bank of the issued command |

## Verification
Random heads with mixed types, fetch flags and ages are run under each tiebreak mode and with three sets of timing values, one of which uses zeros. This shows whether the selection order follows the chosen rule while the legality filter is under steady pressure. Directed sequences then isolate single rules. An activate followed by a held column command and a held precharge shows whether t_rcd, t_ras and t_rp hold exactly. Reads that alternate between ranks show the rank-switch gap apart from plain burst spacing. A write followed by a same-rank read shows the write-to-read wait, and a run of activates to one rank shows the fifth one held back by the rolling window.

// File: rtl/fas_pkg.sv
`timescale 1ns/1ps
package fas_pkg;

  typedef enum logic [1:0] {
    CMD_ACT = 2'd0,
    CMD_RD  = 2'd1,
    CMD_WR  = 2'd2,
    CMD_PRE = 2'd3
  } cmd_e;

  typedef enum logic [1:0] {
    TIE_AGE   = 2'd0,
    TIE_QUEUE = 2'd1,
    TIE_CLASS = 2'd2,
    TIE_ALT   = 2'd3
  } tie_e;

  // value loaded so that a rule of t cycles is met when the counter reaches zero
  function automatic int unsigned wait_load(input int unsigned t);
    return (t == 0) ? 0 : t - 1;
  endfunction

  function automatic int unsigned count_down(input int unsigned c);
    return (c == 0) ? 0 : c - 1;
  endfunction

  function automatic int unsigned keep_later(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // a burst fits when its latency covers the remaining bus wait
  function automatic logic bus_fits(input int unsigned lat, input int unsigned wait_cnt);
    return lat >= wait_cnt;
  endfunction

  // class order for tiebreak: fetch, then read, then the rest
  function automatic logic [1:0] class_rank(input logic fetch, input logic [1:0] typ);
    if (fetch) return 2'd0;
    if (typ == CMD_RD) return 2'd1;
    return 2'd2;
  endfunction

endpackage

// File: rtl/fas_bank_timer.sv
`timescale 1ns/1ps
module fas_bank_timer
  import fas_pkg::*;
#(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] t_rp,
  input  logic [TW-1:0] t_rcd,
  input  logic [TW-1:0] t_ras,
  input  logic          ev_act,
  input  logic          ev_pre,
  output logic          act_ok,
  output logic          col_ok,
  output logic          pre_ok
);

  logic [TW-1:0] act_wait;
  logic [TW-1:0] col_wait;
  logic [TW-1:0] pre_wait;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_wait <= '0;
      col_wait <= '0;
      pre_wait <= '0;
    end else begin
      act_wait <= ev_pre ? TW'(keep_later(count_down(act_wait), wait_load(t_rp)))
                         : TW'(count_down(act_wait));
      col_wait <= ev_act ? TW'(keep_later(count_down(col_wait), wait_load(t_rcd)))
                         : TW'(count_down(col_wait));
      pre_wait <= ev_act ? TW'(keep_later(count_down(pre_wait), wait_load(t_ras)))
                         : TW'(count_down(pre_wait));
    end
  end

  assign act_ok = (act_wait == '0);
  assign col_ok = (col_wait == '0);
  assign pre_ok = (pre_wait == '0);

endmodule

// File: rtl/fas_rank_timer.sv
`timescale 1ns/1ps
module fas_rank_timer
  import fas_pkg::*;
#(
  parameter int TW       = 8,
  parameter int CW       = 10,
  parameter int FAW_ACTS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] t_faw,
  input  logic [TW-1:0] t_cwd,
  input  logic [TW-1:0] t_burst,
  input  logic [TW-1:0] t_wtr,
  input  logic          ev_act,
  input  logic          ev_wr,
  output logic          faw_ok,
  output logic          wtr_ok
);

  logic [TW-1:0]       faw_slot [FAW_ACTS];
  logic [FAW_ACTS-1:0] slot_free;
  logic [FAW_ACTS-1:0] slot_load;
  logic [CW-1:0]       wtr_wait;

  // first free slot takes the new activate
  always_comb begin
    slot_load = '0;
    for (int s = 0; s < FAW_ACTS; s++) begin
      if (slot_free[s] && (slot_load == '0)) slot_load[s] = ev_act;
    end
  end

  for (genvar s = 0; s < FAW_ACTS; s++) begin : g_slot
    assign slot_free[s] = (faw_slot[s] == '0);
    always_ff @(posedge clk) begin
      if (!rst_n) faw_slot[s] <= '0;
      else if (slot_load[s]) faw_slot[s] <= TW'(wait_load(t_faw));
      else faw_slot[s] <= TW'(count_down(faw_slot[s]));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) wtr_wait <= '0;
    else if (ev_wr)
      wtr_wait <= CW'(keep_later(count_down(wtr_wait),
                                 wait_load(t_cwd + t_burst + t_wtr)));
    else wtr_wait <= CW'(count_down(wtr_wait));
  end

  assign faw_ok = |slot_free;
  assign wtr_ok = (wtr_wait == '0);

endmodule

// File: rtl/fas_bus_timer.sv
`timescale 1ns/1ps
module fas_bus_timer
  import fas_pkg::*;
#(
  parameter int TW     = 8,
  parameter int CW     = 10,
  parameter int RANK_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TW-1:0]     t_cas,
  input  logic [TW-1:0]     t_cwd,
  input  logic [TW-1:0]     t_burst,
  input  logic [TW-1:0]     t_rtrs,
  input  logic              ev_col,
  input  logic              ev_is_wr,
  input  logic [RANK_W-1:0] ev_rank,
  output logic [CW-1:0]     same_cnt,
  output logic [CW-1:0]     switch_cnt,
  output logic [RANK_W-1:0] last_rank
);

  logic [TW-1:0] lat;
  assign lat = ev_is_wr ? t_cwd : t_cas;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      same_cnt   <= '0;
      switch_cnt <= '0;
      last_rank  <= '0;
    end else if (ev_col) begin
      same_cnt   <= CW'(keep_later(count_down(same_cnt), wait_load(lat + t_burst)));
      switch_cnt <= CW'(keep_later(count_down(switch_cnt),
                                   wait_load(lat + t_burst + t_rtrs)));
      last_rank  <= ev_rank;
    end else begin
      same_cnt   <= CW'(count_down(same_cnt));
      switch_cnt <= CW'(count_down(switch_cnt));
    end
  end

endmodule

// File: rtl/fas_picker.sv
`timescale 1ns/1ps
module fas_picker
  import fas_pkg::*;
#(
  parameter int NUM_Q = 8,
  parameter int AGE_W = 8,
  parameter int Q_W   = 3
) (
  input  logic [1:0]             tie_mode,
  input  logic [NUM_Q-1:0]       legal,
  input  logic [NUM_Q*AGE_W-1:0] age,
  input  logic [NUM_Q-1:0]       fetch,
  input  logic [NUM_Q*2-1:0]     typ,
  output logic                   grant_v,
  output logic [Q_W-1:0]         grant_q
);

  logic             found;
  logic             take;
  logic [Q_W-1:0]   best;
  logic [AGE_W-1:0] best_age;
  logic [1:0]       best_cls;
  logic [AGE_W-1:0] cur_age;
  logic [1:0]       cur_cls;

  always_comb begin
    found    = 1'b0;
    best     = '0;
    best_age = '0;
    best_cls = 2'd3;
    take     = 1'b0;
    cur_age  = '0;
    cur_cls  = '0;
    for (int q = 0; q < NUM_Q; q++) begin
      cur_age = age[q*AGE_W +: AGE_W];
      cur_cls = class_rank(fetch[q], typ[2*q +: 2]);
      if (!found) take = 1'b1;
      else begin
        case (tie_e'(tie_mode))
          TIE_AGE:   take = cur_age < best_age;
          TIE_CLASS: take = cur_cls < best_cls;
          default:   take = 1'b0;
        endcase
      end
      if (legal[q] && take) begin
        found    = 1'b1;
        best     = Q_W'(q);
        best_age = cur_age;
        best_cls = cur_cls;
      end
    end
  end

  assign grant_v = found;
  assign grant_q = best;

endmodule

// File: rtl/fas_sched.sv
`timescale 1ns/1ps
module fas_sched
  import fas_pkg::*;
#(
  parameter int NUM_RANKS      = 2,
  parameter int BANKS_PER_RANK = 4,
  parameter int AGE_W          = 8,
  parameter int TW             = 8
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic [TW-1:0]                             t_rcd,
  input  logic [TW-1:0]                             t_rp,
  input  logic [TW-1:0]                             t_ras,
  input  logic [TW-1:0]                             t_cas,
  input  logic [TW-1:0]                             t_cwd,
  input  logic [TW-1:0]                             t_burst,
  input  logic [TW-1:0]                             t_rtrs,
  input  logic [TW-1:0]                             t_wtr,
  input  logic [TW-1:0]                             t_faw,
  input  logic [1:0]                                tie_mode,
  input  logic [NUM_RANKS*BANKS_PER_RANK-1:0]       cand_valid,
  input  logic [NUM_RANKS*BANKS_PER_RANK*2-1:0]     cand_type,
  input  logic [NUM_RANKS*BANKS_PER_RANK-1:0]       cand_fetch,
  input  logic [NUM_RANKS*BANKS_PER_RANK*AGE_W-1:0] cand_age,
  output logic                                      issue_valid,
  output logic [1:0]                                issue_type,
  output logic [((NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1)-1:0]           issue_rank,
  output logic [((BANKS_PER_RANK > 1) ? $clog2(BANKS_PER_RANK) : 1)-1:0] issue_bank
);

  localparam int NUM_Q  = NUM_RANKS * BANKS_PER_RANK;
  localparam int RANK_W = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1;
  localparam int BANK_W = (BANKS_PER_RANK > 1) ? $clog2(BANKS_PER_RANK) : 1;
  localparam int Q_W    = (NUM_Q > 1) ? $clog2(NUM_Q) : 1;
  localparam int CW     = TW + 2;

  // named internal events, observed by the checker
  logic [NUM_Q-1:0]     cand_legal;
  logic [Q_W-1:0]       issue_q;
  logic [NUM_Q-1:0]     issue_hit;
  logic                 col_issue;
  logic [NUM_RANKS-1:0] rank_act;
  logic [NUM_RANKS-1:0] rank_wr;
  logic [NUM_RANKS-1:0] rank_faw_ok;
  logic [NUM_RANKS-1:0] rank_wtr_ok;
  logic [CW-1:0]        same_cnt;
  logic [CW-1:0]        switch_cnt;
  logic [RANK_W-1:0]    last_rank;

  assign issue_type = cand_type[2*issue_q +: 2];
  assign issue_rank = RANK_W'(issue_q / Q_W'(BANKS_PER_RANK));
  assign issue_bank = BANK_W'(issue_q % Q_W'(BANKS_PER_RANK));
  assign col_issue  = issue_valid && (issue_type == CMD_RD || issue_type == CMD_WR);

  for (genvar q = 0; q < NUM_Q; q++) begin : g_hit
    assign issue_hit[q] = issue_valid && (issue_q == Q_W'(q));
  end

  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
    assign rank_act[r] = issue_valid && issue_type == CMD_ACT && issue_rank == RANK_W'(r);
    assign rank_wr[r]  = issue_valid && issue_type == CMD_WR  && issue_rank == RANK_W'(r);

    fas_rank_timer #(.TW(TW), .CW(CW), .FAW_ACTS(4)) u_rank (
      .clk    (clk),
      .rst_n  (rst_n),
      .t_faw  (t_faw),
      .t_cwd  (t_cwd),
      .t_burst(t_burst),
      .t_wtr  (t_wtr),
      .ev_act (rank_act[r]),
      .ev_wr  (rank_wr[r]),
      .faw_ok (rank_faw_ok[r]),
      .wtr_ok (rank_wtr_ok[r])
    );
  end

  fas_bus_timer #(.TW(TW), .CW(CW), .RANK_W(RANK_W)) u_bus (
    .clk       (clk),
    .rst_n     (rst_n),
    .t_cas     (t_cas),
    .t_cwd     (t_cwd),
    .t_burst   (t_burst),
    .t_rtrs    (t_rtrs),
    .ev_col    (col_issue),
    .ev_is_wr  (issue_type == CMD_WR),
    .ev_rank   (issue_rank),
    .same_cnt  (same_cnt),
    .switch_cnt(switch_cnt),
    .last_rank (last_rank)
  );

  for (genvar q = 0; q < NUM_Q; q++) begin : g_queue
    localparam int QR = q / BANKS_PER_RANK;
    logic          act_ok, col_ok, pre_ok, ok;
    logic [CW-1:0] bus_wait;
    cmd_e          kind;

    assign kind     = cmd_e'(cand_type[2*q +: 2]);
    assign bus_wait = (last_rank == RANK_W'(QR)) ? same_cnt : switch_cnt;

    fas_bank_timer #(.TW(TW)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .t_rp  (t_rp),
      .t_rcd (t_rcd),
      .t_ras (t_ras),
      .ev_act(issue_hit[q] && issue_type == CMD_ACT),
      .ev_pre(issue_hit[q] && issue_type == CMD_PRE),
      .act_ok(act_ok),
      .col_ok(col_ok),
      .pre_ok(pre_ok)
    );

    always_comb begin
      case (kind)
        CMD_ACT: ok = act_ok && rank_faw_ok[QR];
        CMD_RD:  ok = col_ok && rank_wtr_ok[QR] && bus_fits(t_cas, bus_wait);
        CMD_WR:  ok = col_ok && bus_fits(t_cwd, bus_wait);
        default: ok = pre_ok;
      endcase
    end

    assign cand_legal[q] = cand_valid[q] && ok;
  end

  fas_picker #(.NUM_Q(NUM_Q), .AGE_W(AGE_W), .Q_W(Q_W)) u_pick (
    .tie_mode(tie_mode),
    .legal   (cand_legal),
    .age     (cand_age),
    .fetch   (cand_fetch),
    .typ     (cand_type),
    .grant_v (issue_valid),
    .grant_q (issue_q)
  );

endmodule

// File: rtl/fas_sched_chk.sv
`timescale 1ns/1ps
module fas_sched_chk #(
  parameter int NUM_Q = 8,
  parameter int Q_W   = 3,
  parameter int TW    = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             issue_valid,
  input logic [1:0]       issue_type,
  input logic [Q_W-1:0]   issue_q,
  input logic [NUM_Q-1:0] cand_valid,
  input logic [NUM_Q-1:0] cand_legal,
  input logic [1:0]       tie_mode,
  input logic [TW-1:0]    t_rcd,
  input logic [TW-1:0]    t_ras
);

  logic [NUM_Q-1:0] below_mask;
  always_comb begin
    for (int i = 0; i < NUM_Q; i++) below_mask[i] = (Q_W'(i) < issue_q);
  end

  // R2: legality never marks an absent head
  assert_legal_subset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_legal & ~cand_valid) == '0);

  // R2: the granted head was legal
  assert_grant_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> cand_legal[issue_q]);

  // R2: work conserving, and silent when nothing is legal
  assert_work_conserving_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_legal != '0) == issue_valid);

  // R3: column command not in the cycle after its activate when t_rcd exceeds one
  assert_rcd_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && issue_type == 2'd0 && t_rcd > 1)
    |=> !(issue_valid && (issue_type == 2'd1 || issue_type == 2'd2) &&
          issue_q == $past(issue_q)));

  // R3: precharge not in the cycle after its activate when t_ras exceeds one
  assert_ras_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && issue_type == 2'd0 && t_ras > 1)
    |=> !(issue_valid && issue_type == 2'd3 && issue_q == $past(issue_q)));

  // R8: queue-order mode grants the lowest legal index
  assert_queue_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && (tie_mode == 2'd1 || tie_mode == 2'd3))
    |-> ((cand_legal & below_mask) == '0));

endmodule

bind fas_sched fas_sched_chk #(.NUM_Q(NUM_Q), .Q_W(Q_W), .TW(TW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .issue_valid(issue_valid),
  .issue_type (issue_type),
  .issue_q    (issue_q),
  .cand_valid (cand_valid),
  .cand_legal (cand_legal),
  .tie_mode   (tie_mode),
  .t_rcd      (t_rcd),
  .t_ras      (t_ras)
);

// File: tb/fas_sched_tb.sv
`timescale 1ns/1ps
module fas_sched_tb;

  localparam int NR = 2;
  localparam int NB = 4;
  localparam int Q  = NR * NB;
  localparam int NEG = -100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] t_rcd, t_rp, t_ras, t_cas, t_cwd, t_burst, t_rtrs, t_wtr, t_faw;
  logic [1:0] tie_mode;
  logic [Q-1:0] cv, cf;
  logic [2*Q-1:0] ct;
  logic [8*Q-1:0] ca;
  logic issue_valid;
  logic [1:0] issue_type;
  logic issue_rank;
  logic [1:0] issue_bank;

  always #10 clk = ~clk;

  fas_sched u_dut (
    .clk(clk), .rst_n(rst_n),
    .t_rcd(t_rcd), .t_rp(t_rp), .t_ras(t_ras), .t_cas(t_cas), .t_cwd(t_cwd),
    .t_burst(t_burst), .t_rtrs(t_rtrs), .t_wtr(t_wtr), .t_faw(t_faw),
    .tie_mode(tie_mode), .cand_valid(cv), .cand_type(ct), .cand_fetch(cf),
    .cand_age(ca), .issue_valid(issue_valid), .issue_type(issue_type),
    .issue_rank(issue_rank), .issue_bank(issue_bank)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // reference state as absolute issue cycles
  int now;
  int act_t[Q], pre_t[Q];
  int wr_end[NR];
  int faw_t[NR][4];
  int bus_end, last_rk;

  function automatic int typ_of(int q); return int'(ct[2*q +: 2]); endfunction

  function automatic bit legal_now(int q);
    int ty = typ_of(q);
    int r = q / NB;
    int lat, gap, busy;
    if (!cv[q]) return 0;
    case (ty)
      0: begin
        busy = 0;
        for (int i = 0; i < 4; i++) if (now < faw_t[r][i] + int'(t_faw)) busy++;
        return (now >= pre_t[q] + int'(t_rp)) && (busy < 4);
      end
      3: return now >= act_t[q] + int'(t_ras);
      default: begin
        lat = (ty == 1) ? int'(t_cas) : int'(t_cwd);
        gap = (last_rk >= 0 && last_rk != r) ? int'(t_rtrs) : 0;
        if (now < act_t[q] + int'(t_rcd)) return 0;
        if (ty == 1 && now < wr_end[r] + int'(t_wtr)) return 0;
        return now + lat >= bus_end + gap;
      end
    endcase
  endfunction

  function automatic int cls_of(int q);
    if (cf[q]) return 0;
    return (typ_of(q) == 1) ? 1 : 2;
  endfunction

  task automatic pick(output bit v, output int w);
    v = 0; w = 0;
    for (int q = 0; q < Q; q++) begin
      if (legal_now(q)) begin
        if (!v) begin v = 1; w = q; end
        else if (tie_mode == 2'd0 && ca[8*q +: 8] < ca[8*w +: 8]) w = q;
        else if (tie_mode == 2'd2 && cls_of(q) < cls_of(w)) w = q;
      end
    end
  endtask

  task automatic commit(int q);
    int ty = typ_of(q);
    int r = q / NB;
    int lat, old;
    case (ty)
      0: begin
        act_t[q] = now;
        old = 0;
        for (int i = 1; i < 4; i++) if (faw_t[r][i] < faw_t[r][old]) old = i;
        faw_t[r][old] = now;
      end
      3: pre_t[q] = now;
      default: begin
        lat = (ty == 1) ? int'(t_cas) : int'(t_cwd);
        bus_end = now + lat + int'(t_burst);
        last_rk = r;
        if (ty == 2) wr_end[r] = now + int'(t_cwd) + int'(t_burst);
      end
    endcase
  endtask

  task automatic check(string tag, bit ok, string detail);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s", tag, detail);
    end
  endtask

  // called at a falling edge with inputs already driven
  task automatic step(string tag);
    bit ev; int eq; bit ok;
    #5;
    pick(ev, eq);
    ok = (issue_valid == ev);
    if (ev) ok = ok && issue_type == ct[2*eq +: 2] &&
                 int'(issue_rank) == eq / NB && int'(issue_bank) == eq % NB;
    check(tag, ok, $sformatf("cycle %0d got v=%0d t=%0d r=%0d b=%0d, expected v=%0d t=%0d r=%0d b=%0d",
          now, issue_valid, issue_type, issue_rank, issue_bank, ev,
          ev ? typ_of(eq) : 0, eq / NB, eq % NB));
    if (ev) commit(eq);
    @(posedge clk);
    now++;
    @(negedge clk);
  endtask

  task automatic set_t(int rcd, int rp, int ras, int cas, int cwd, int bst,
                       int rtrs, int wtr, int faw);
    t_rcd = 8'(rcd); t_rp = 8'(rp); t_ras = 8'(ras); t_cas = 8'(cas);
    t_cwd = 8'(cwd); t_burst = 8'(bst); t_rtrs = 8'(rtrs); t_wtr = 8'(wtr);
    t_faw = 8'(faw);
  endtask

  task automatic do_reset();
    rst_n = 0; cv = '0; ct = '0; cf = '0; ca = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    now = 0; bus_end = NEG; last_rk = -1;
    for (int q = 0; q < Q; q++) begin act_t[q] = NEG; pre_t[q] = NEG; end
    for (int r = 0; r < NR; r++) begin
      wr_end[r] = NEG;
      for (int i = 0; i < 4; i++) faw_t[r][i] = NEG;
    end
  endtask

  task automatic only(int q, int ty);
    cv = '0; cf = '0;
    cv[q] = 1'b1;
    ct[2*q +: 2] = 2'(ty);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20100802));
    tie_mode = 2'd1;
    set_t(3, 4, 6, 3, 2, 2, 2, 3, 10);
    do_reset();

    // R1: precharge and read both legal in the very first cycle
    only(0, 3); step("R1");
    do_reset();
    only(4, 1); step("R1");

    // R2: nothing valid, then a held precharge under t_ras
    do_reset();
    cv = '0; step("R2");
    only(0, 0); step("R2");
    only(0, 3); repeat (3) step("R2");

    // R3: activate, held column, held precharge, held activate
    do_reset();
    only(1, 0); step("R3");
    only(1, 1); repeat (4) step("R3");
    only(1, 3); repeat (4) step("R3");
    only(1, 0); repeat (6) step("R3");

    // R4: reads alternating between ranks contend for the data bus
    do_reset();
    cv = '0; cv[0] = 1; cv[4] = 1; ct[1:0] = 2'd1; ct[9:8] = 2'd1;
    tie_mode = 2'd1;
    repeat (4) begin
      step("R4");
      tie_mode = (issue_rank == 1'b0) ? 2'd1 : 2'd1;
      cv[0] = ~cv[0]; cv[4] = ~cv[4];
      if (cv == '0) cv[4] = 1;
    end
    cv = '0; cv[0] = 1; cv[4] = 1;
    repeat (10) step("R4");

    // R5: write then read in the same rank
    do_reset();
    only(2, 2); step("R5");
    only(3, 1); repeat (10) step("R5");

    // R6: activates to one rank hit the rolling window
    do_reset();
    cv = '0; cv[3:0] = 4'hF; ct[7:0] = 8'h00;
    repeat (14) step("R6");

    // R10: field mapping of the issued command
    do_reset();
    only(5, 2); step("R10");
    only(6, 0); step("R10");
    only(7, 3); step("R10");

    // R7, R9: all activates legal, distinct ages and one fetch flag
    do_reset();
    cv = '1; ct = '0; cf = '0; cf[6] = 1;
    for (int q = 0; q < Q; q++) ca[8*q +: 8] = 8'(50 - 5 * q);
    tie_mode = 2'd0; step("R7");
    do_reset();
    cv = '1; ct = '0; cf = '0; cf[6] = 1; ct[9:8] = 2'd1;
    tie_mode = 2'd2; step("R9");
    do_reset();
    cv = '1; ct = '0; ct[9:8] = 2'd1; ct[11:10] = 2'd1;
    tie_mode = 2'd2; step("R9");

    // random mixes under three timing sets
    for (int ph = 0; ph < 3; ph++) begin
      case (ph)
        0: set_t(3, 4, 6, 4, 3, 2, 2, 3, 12);
        1: set_t(0, 0, 1, 1, 0, 1, 0, 0, 0);
        default: set_t(5, 3, 9, 6, 2, 4, 3, 5, 20);
      endcase
      do_reset();
      for (int n = 0; n < 2000; n++) begin
        for (int q = 0; q < Q; q++) begin
          cv[q] = ($urandom % 100) < 55;
          ct[2*q +: 2] = 2'($urandom % 4);
          cf[q] = ($urandom % 4) == 0;
          ca[8*q +: 8] = 8'($urandom % 256);
        end
        tie_mode = 2'($urandom % 4);
        case (tie_mode)
          2'd0: step("R7");
          2'd2: step("R9");
          default: step("R8");
        endcase
      end
    end

    done = 1;
    summary();
    $finish;
  end

endmodule